// File: doc/BRIEF.md
# Programmable Clock Synthesizer Divider

This block derives a slow sensor clock from the fast system clock. A single 32-bit configuration word arrives through a one-cycle write strobe. It packs four fields: a low-phase count, a high-phase count, a hold count and an enable bit. While the enable is set, the block drives a divided clock whose high and low phases each last their field value plus one system cycle. Because the two phase fields are independent, odd division ratios are possible. The full range of ratios runs from 2:1 up to 512:1. For ratio R, software normally writes key = R − 2 with low = (key+1)>>1, high = key>>1 and hold = high.

The block is controlled by a four-state machine:

- **OFF**: the output is low and the counter is cleared.
- **SETTLE**: the hold delay that runs after the enable is set.
- **HIGH**: the high phase.
- **LOW**: the low phase.

The state changes are:

- **OFF→SETTLE**: the enable becomes set.
- **SETTLE→HIGH**: the hold count has expired.
- **HIGH→LOW**: the high count has expired. The phase fields are sampled here.
- **LOW→HIGH**: the low count has expired.
- **any→OFF**: a write clears the enable.

A one-cycle strobe marks the first cycle of every high phase.

The write is sampled at a clock edge. A write that clears the enable puts the machine in OFF at that same edge. A write that sets the enable from OFF starts SETTLE at that same edge.

Top module: `clksyn_div`

## Requirements
- R1: While reset is asserted and after it is released with no write, `div_clk` and `rise_stb` stay low: the configuration word resets to zero, which disables the divider.
- R2: Field positions in `cfg_wdata`: low count [7:0], high count [15:8], hold count [23:16], enable [24]. Bits [31:25] are ignored, and a word with bit 24 clear keeps the output low whatever the other fields hold.
- R3: A write with bit 24 clear forces `div_clk` and `rise_stb` low from the cycle after the write edge, even in mid-phase.
- R4: A write that sets the enable while the divider is off keeps `div_clk` low for hold+1 cycles after the write edge, then the first high phase begins.
- R5: Each high phase lasts high+1 system cycles.
- R6: Each low phase lasts low+1 system cycles, so the period is low+high+2 cycles.
- R7: `rise_stb` is high for exactly one cycle: the first cycle of each high phase.
- R8: A write that keeps the enable set while running does not restart the hold delay or cut the current phase. The new low and high counts are taken at the start of the next low phase, and the following high phase uses the new high count.
- R9: Ratio limits: low = high = 0 toggles the output every cycle (2:1), and low = high = 255 gives a 512-cycle period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration word |
| div_clk | output | 1 | Divided sensor clock |
| rise_stb | output | 1 | One-cycle pulse on each rising edge of `div_clk` |

## Verification
A wrong state or a corrupted counter in this block shows up directly on `div_clk`. It appears as a high or low run that is too long or too short, or as a strobe missing at a rising edge. The run is off within one phase, so the fault is visible at most 256 cycles later.

A phase field sampled at the wrong moment shows as a wrong length in the phase that follows a mid-run write. The bench therefore compares every cycle of `div_clk` and `rise_stb` against its expected value, instead of sampling only at edges.

// File: rtl/clksyn_pkg.sv
package clksyn_pkg;
    parameter int CFG_W    = 32;
    parameter int FLD_W    = 8;
    parameter int LO_LSB   = 0;
    parameter int HI_LSB   = 8;
    parameter int HOLD_LSB = 16;
    parameter int EN_POS   = 24;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_SETTLE = 2'd1,
        ST_HIGH   = 2'd2,
        ST_LOW    = 2'd3
    } div_state_e;

    typedef struct packed {
        logic             en;
        logic [FLD_W-1:0] hold;
        logic [FLD_W-1:0] hi;
        logic [FLD_W-1:0] lo;
    } div_cfg_t;
endpackage

// File: rtl/clksyn_cfg_reg.sv
module clksyn_cfg_reg
    import clksyn_pkg::*;
#(
    parameter int W = CFG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output div_cfg_t     cfg_nx
);
    div_cfg_t cfg_q;
    div_cfg_t wr_fields;
    logic     unused_hi_bits;

    assign wr_fields.lo   = wdata[LO_LSB   +: FLD_W];
    assign wr_fields.hi   = wdata[HI_LSB   +: FLD_W];
    assign wr_fields.hold = wdata[HOLD_LSB +: FLD_W];
    assign wr_fields.en   = wdata[EN_POS];
    assign unused_hi_bits = ^wdata[W-1:EN_POS+1];

    // Value the word holds after this edge; the sequencer acts on it at once.
    assign cfg_nx = we ? wr_fields : cfg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_nx;
    end
endmodule

// File: rtl/clksyn_phase_cnt.sv
module clksyn_phase_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] ld_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt_q <= '0;
        else if (clr)        cnt_q <= '0;
        else if (load)       cnt_q <= ld_val;
        else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/clksyn_div.sv
module clksyn_div
    import clksyn_pkg::*;
#(
    parameter int WORD_W = CFG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic              div_clk,
    output logic              rise_stb
);
    div_cfg_t         cfg_nx;
    div_state_e       state_q, state_d;
    logic [FLD_W-1:0] hi_sh_q, hi_sh_d;
    logic             cnt_clr, cnt_ld, cnt_zero;
    logic [FLD_W-1:0] cnt_val;
    logic             stb_q;

    clksyn_cfg_reg #(.W(WORD_W)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .wdata  (cfg_wdata),
        .cfg_nx (cfg_nx)
    );

    clksyn_phase_cnt #(.W(FLD_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (cnt_clr),
        .load   (cnt_ld),
        .ld_val (cnt_val),
        .zero   (cnt_zero)
    );

    // Next-state and counter control
    always_comb begin
        state_d = state_q;
        hi_sh_d = hi_sh_q;
        cnt_clr = 1'b0;
        cnt_ld  = 1'b0;
        cnt_val = '0;
        if (!cfg_nx.en) begin
            state_d = ST_OFF;
            cnt_clr = 1'b1;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    state_d = ST_SETTLE;
                    cnt_ld  = 1'b1;
                    cnt_val = cfg_nx.hold;
                    hi_sh_d = cfg_nx.hi;
                end
                ST_SETTLE: if (cnt_zero) begin
                    state_d = ST_HIGH;
                    cnt_ld  = 1'b1;
                    cnt_val = hi_sh_q;
                end
                ST_HIGH: if (cnt_zero) begin
                    state_d = ST_LOW;
                    cnt_ld  = 1'b1;
                    cnt_val = cfg_nx.lo;
                    hi_sh_d = cfg_nx.hi;
                end
                ST_LOW: if (cnt_zero) begin
                    state_d = ST_HIGH;
                    cnt_ld  = 1'b1;
                    cnt_val = hi_sh_q;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            hi_sh_q <= '0;
            stb_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            hi_sh_q <= hi_sh_d;
            stb_q   <= (state_d == ST_HIGH) && (state_q != ST_HIGH);
        end
    end

    // Outputs
    always_comb begin
        div_clk  = (state_q == ST_HIGH);
        rise_stb = stb_q;
    end
endmodule

// File: rtl/clksyn_div_chk.sv
module clksyn_div_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_we,
    input logic wr_en_bit,
    input logic div_clk,
    input logic rise_stb
);
    logic [9:0] hi_run, lo_run;
    logic       en_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run  <= '0;
            lo_run  <= '0;
            en_seen <= 1'b0;
        end else begin
            if (cfg_we) en_seen <= wr_en_bit;
            hi_run <= div_clk ? hi_run + 10'd1 : 10'd0;
            lo_run <= (!div_clk && en_seen) ? lo_run + 10'd1 : 10'd0;
        end
    end

    p_stb_on_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |-> (div_clk && !$past(div_clk)));
    p_rise_strobed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (div_clk && !$past(div_clk)) |-> rise_stb);
    p_off_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !wr_en_bit) |=> (!div_clk && !rise_stb));
    p_start_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && wr_en_bit && !en_seen) |=> !div_clk);
    p_high_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        div_clk |-> (hi_run < 10'd256));
    p_low_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!div_clk && en_seen) |-> (lo_run < 10'd256));
endmodule

bind clksyn_div clksyn_div_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .wr_en_bit (cfg_wdata[clksyn_pkg::EN_POS]),
    .div_clk   (div_clk),
    .rise_stb  (rise_stb)
);

// File: tb/sim_clksyn_div.sv
module sim_clksyn_div;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        div_clk, rise_stb;
    int          checks = 0;
    int          errs = 0;
    bit          done = 0;

    typedef struct {
        logic  clk_e;
        logic  stb_e;
        string req;
    } exp_t;
    exp_t sbq[$];
    exp_t it;

    always #2 clk = ~clk;

    clksyn_div u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .div_clk(div_clk), .rise_stb(rise_stb)
    );

    task automatic push(input logic c, input logic s, input string r);
        exp_t e;
        e.clk_e = c; e.stb_e = s; e.req = r;
        sbq.push_back(e);
    endtask

    task automatic push_low(input int n, input string r);
        for (int i = 0; i < n; i++) push(1'b0, 1'b0, r);
    endtask

    // First high cycle carries the strobe (R7)
    task automatic push_high(input int n, input string r);
        push(1'b1, 1'b1, "R7");
        for (int i = 1; i < n; i++) push(1'b1, 1'b0, r);
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = d;
        @(posedge clk);
    endtask

    task automatic wr_end();
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic drain();
        wait (sbq.size() == 0);
    endtask

    task automatic disable_div();
        wr(32'h0000_0000);
        push_low(6, "R3");
        wr_end();
        drain();
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errs, checks);
    endtask

    // Monitor: pop and compare one expected item per cycle
    always @(negedge clk) begin
        if (rst_n && sbq.size() > 0) begin
            it = sbq.pop_front();
            checks++;
            if (div_clk !== it.clk_e || rise_stb !== it.stb_e) begin
                errs++;
                $display("FAIL %s: actual clk=%b stb=%b expected clk=%b stb=%b at %0t",
                         it.req, div_clk, rise_stb, it.clk_e, it.stb_e, $time);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errs++;
            $display("FAIL watchdog: actual=timeout expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: outputs low during reset
        repeat (3) @(negedge clk);
        checks++;
        if (div_clk !== 1'b0) begin
            errs++; $display("FAIL R1: actual div_clk=%b expected 0", div_clk);
        end
        checks++;
        if (rise_stb !== 1'b0) begin
            errs++; $display("FAIL R1: actual rise_stb=%b expected 0", rise_stb);
        end
        rst_n = 1'b1;
        @(posedge clk);
        push_low(8, "R1");
        drain();

        // R2: enable clear, other fields and upper bits set -> stays low
        wr(32'hFE03_0201);
        push_low(10, "R2");
        wr_end();
        drain();

        // R9: 2:1 ratio, hold 0
        wr(32'h0100_0000);
        push_low(1, "R4");
        for (int i = 0; i < 6; i++) begin
            push_high(1, "R9");
            push_low(1, "R9");
        end
        wr_end();
        drain();
        disable_div();

        // R4/R5/R6: hold 2, high 2, low 3 (ratio 7)
        wr(32'h0102_0203);
        push_low(3, "R4");
        for (int i = 0; i < 3; i++) begin
            push_high(3, "R5");
            push_low(4, "R6");
        end
        wr_end();
        drain();
        disable_div();

        // R9/R2: all ones -> hold, high, low = 255, enabled, top bits ignored
        wr(32'hFFFF_FFFF);
        push_low(256, "R4");
        push_high(256, "R9");
        push_low(256, "R9");
        push_high(256, "R9");
        wr_end();
        drain();
        disable_div();

        // R8: reconfigure during the first high phase
        wr(32'h0100_0401);
        push_low(1, "R4");
        push_high(5, "R8");
        push_low(3, "R8");
        push_high(2, "R8");
        push_low(3, "R8");
        push_high(2, "R8");
        wr_end();
        @(posedge clk);
        @(posedge clk);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = 32'h0109_0102;
        @(posedge clk);
        @(negedge clk); cfg_we = 1'b0;
        drain();
        disable_div();

        done = 1;
        summary();
        $finish;
    end
endmodule